// File: doc/BRIEF.md
# CAN FD Receive Descriptor Ring Writer

This block takes frames that a CAN or CAN FD receiver has already decoded and stores them in a circular memory region. Each stored frame starts with a 16-byte descriptor. The first 64-bit word of that descriptor holds two 32-bit header words. Its second word holds the first 8 payload bytes. Each further 16 bytes of payload take one more descriptor, so a frame takes between one and five descriptors. Software owns a read offset and gives it to the block. The block owns the write offset and advances it only once every word of a frame is in memory.

Before it accepts a frame, the block checks whether all of the frame's descriptors fit without the write offset catching up with the read offset. A frame that does not fit is discarded. So is any frame that arrives while storage is disabled. Either case sets a sticky overrun flag, and the header of the next stored frame reports that flag. Memory is reached through a simple port that writes one 64-bit word per cycle. Addresses on that port are byte offsets inside the ring.

Top module: `canfd_rx_ring_writer`

## Requirements
- R1: Header word 0 sits in memory bits 31:0 of the first word of a frame. Bit 31 is 1 for an extended identifier, and bit 30 copies the remote-request flag. An extended identifier fills bits 29:0. A standard identifier's 12 bits go to bits 29:18, and bits 17:0 are zero.
- R2: Header word 1 sits in memory bits 63:32 of the first word. Its bits 31:28 hold the received 4-bit length code exactly as received. Its bits 27:25 hold the three option bits, where option bit 0 (header bit 25) marks an FD frame. Bits 24:3 are zero.
- R3: Header word 1 bit 1 holds the bus-off input and bit 0 holds the error-passive input, both sampled in the cycle the frame is accepted.
- R4: Payload length in bytes depends on the length code. For FD frames, codes 0 to 8 give 0 to 8 bytes, and codes 9 to 15 give 12, 16, 20, 24, 32, 48 and 64 bytes. For classic frames, any code above 8 gives 8 bytes. The block writes ceil(length/8) payload words, and payload byte i is taken from frame data bits 8i+7:8i.
- R5: The header word goes to the current write offset. Payload words follow at successive +8 byte addresses. An address that reaches the ring size wraps to 0, even in the middle of a frame.
- R6: After a stored frame, the write offset moves forward by 16 × (1 + ((length+7)>>4)) bytes modulo the ring size. This happens in one update, on the clock edge of the frame's last memory write. At all other times the write offset holds its value.
- R7: A frame is dropped, with no memory write and no offset change, when the bytes in use plus the frame's descriptor bytes would reach the ring size. In use means (write − read) modulo size. Equal offsets therefore always mean an empty ring.
- R8: A dropped frame sets a sticky overrun flag. The next stored frame reports this flag in header word 1 bit 2, and storing that frame clears the flag.
- R9: While enable is low, every offered frame is accepted and discarded without any memory write, and it sets the overrun flag.
- R10: After reset, the write offset is 0, frmReady is 1 and no write is issued. frmReady is high only while no frame is being stored. A stored frame makes one memory write per cycle, starting in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| enable | input | 1 | Storage enable; when low, frames are discarded |
| ringSize | input | OFF_W | Ring size in bytes, a multiple of 16 |
| rdOffset | input | OFF_W | Software read offset in bytes |
| wrOffset | output | OFF_W | Committed write offset in bytes |
| frmValid | input | 1 | A frame is offered |
| frmReady | output | 1 | Frame accepted when high together with frmValid |
| frmExt | input | 1 | Extended identifier |
| frmRtr | input | 1 | Remote request |
| frmId | input | 30 | Identifier (standard uses bits 11:0) |
| frmDlc | input | 4 | Length code |
| frmOpts | input | 3 | Option bits, bit 0 = FD frame |
| frmData | input | 512 | Payload, byte i in bits 8i+7:8i |
| busOff | input | 1 | Bus-off state of the controller |
| errPassive | input | 1 | Error-passive state of the controller |
| memWe | output | 1 | Memory word write strobe |
| memAddr | output | OFF_W | Byte offset of the written word |
| memData | output | 64 | Written word |

## Verification
A wrong space calculation shows up at once at the ports. A frame that should be dropped produces writes in the cycle after it is offered, and a frame that should be stored produces none and leaves frmReady high. A wrong cursor or commit value is harder to see. It appears as a payload word at the wrong byte address during the frame, or as a write offset off by whole descriptors at the last write. The frame after that then lands in the wrong slot. A lost or stuck overrun flag stays invisible until the next stored header, which is why every drop scenario is followed by a stored frame whose header bit 2 is compared.

// File: rtl/canfd_rx_ring_pkg.sv
package canfd_rx_ring_pkg;

  localparam int ID_W      = 30;
  localparam int OPT_W     = 3;
  localparam int MAX_BYTES = 64;
  localparam int MAX_WORDS = MAX_BYTES / 8;
  localparam int SEL_W     = $clog2(MAX_WORDS + 1);

  typedef struct packed {
    logic             load;    // accept frame and start storing
    logic             drop;    // accept frame and discard it
    logic             emit;    // write one memory word
    logic             commit;  // last word: publish write offset
    logic [SEL_W-1:0] sel;     // 0 = header, k = payload word k-1
  } ringStrobe_t;

  function automatic logic [6:0] frameLen(input logic [3:0] code, input logic isFd);
    logic [6:0] n;
    if (code <= 4'd8) n = {3'b0, code};
    else if (!isFd) n = 7'd8;
    else begin
      case (code)
        4'd9:    n = 7'd12;
        4'd10:   n = 7'd16;
        4'd11:   n = 7'd20;
        4'd12:   n = 7'd24;
        4'd13:   n = 7'd32;
        4'd14:   n = 7'd48;
        default: n = 7'd64;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/canfd_rx_ring_ctrl.sv
module canfd_rx_ring_ctrl
  import canfd_rx_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic             enable,
  input  logic             fits,
  input  logic [SEL_W-1:0] nWordsQ,
  output logic             frmReady,
  output ringStrobe_t      strobe
);

  logic             busyQ;
  logic [SEL_W-1:0] idxQ;

  assign frmReady = !busyQ;

  always_comb begin
    strobe        = '0;
    strobe.load   = !busyQ && frmValid && enable && fits;
    strobe.drop   = !busyQ && frmValid && !(enable && fits);
    strobe.emit   = busyQ;
    strobe.commit = busyQ && (idxQ == nWordsQ);
    strobe.sel    = idxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (strobe.load) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else if (strobe.emit) begin
      if (strobe.commit) busyQ <= 1'b0;
      else idxQ <= idxQ + 1'b1;
    end
  end

  assert_store_starts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady && enable && fits) |=> (!frmReady && strobe.emit && strobe.sel == '0));

  assert_disabled_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady && !enable) |=> (frmReady && !strobe.emit));

  assert_nofit_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady && !fits) |=> !strobe.emit);

endmodule

// File: rtl/canfd_rx_ring_dp.sv
module canfd_rx_ring_dp
  import canfd_rx_ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ringStrobe_t            strobe,
  input  logic [OFF_W-1:0]       ringSize,
  input  logic [OFF_W-1:0]       rdOffset,
  input  logic                   frmExt,
  input  logic                   frmRtr,
  input  logic [ID_W-1:0]        frmId,
  input  logic [3:0]             frmDlc,
  input  logic [OPT_W-1:0]       frmOpts,
  input  logic [MAX_BYTES*8-1:0] frmData,
  input  logic                   busOff,
  input  logic                   errPassive,
  output logic                   fits,
  output logic [SEL_W-1:0]       nWordsQ,
  output logic [OFF_W-1:0]       wrOffset,
  output logic [OFF_W-1:0]       memAddr,
  output logic [63:0]            memData
);

  localparam int W = OFF_W + 1;

  logic [6:0]             inLen;
  logic [7:0]             inRound;
  logic [2:0]             inBds;
  logic [W-1:0]           needB, usedB, ringW;
  logic [W-1:0]           stepSum, commitSum;
  logic [31:0]            hdr0In, hdr1In;
  logic [31:0]            hdr0Q, hdr1Q;
  logic [MAX_BYTES*8-1:0] dataQ;
  logic [OFF_W-1:0]       cursorQ, wrOffsetQ, cursorNext, wrNext;
  logic [2:0]             nBdsQ;
  logic                   stickyOvrQ;
  logic [SEL_W-1:0]       wordIdx;

  assign ringW   = W'(ringSize);
  assign inLen   = frameLen(frmDlc, frmOpts[0]);
  assign inRound = {1'b0, inLen} + 8'd7;
  assign inBds   = 3'd1 + 3'(inRound >> 4);
  assign needB   = W'({inBds, 4'b0000});

  always_comb begin
    if (wrOffsetQ >= rdOffset) usedB = W'(wrOffsetQ) - W'(rdOffset);
    else usedB = W'(wrOffsetQ) + ringW - W'(rdOffset);
  end
  assign fits = (usedB + needB) < ringW;

  assign hdr0In = frmExt ? {1'b1, frmRtr, frmId}
                         : {1'b0, frmRtr, frmId[11:0], 18'd0};
  assign hdr1In = {frmDlc, frmOpts, 22'd0, stickyOvrQ, busOff, errPassive};

  assign stepSum    = W'(cursorQ) + W'(8);
  assign cursorNext = (stepSum >= ringW) ? '0 : OFF_W'(stepSum);
  assign commitSum  = W'(wrOffsetQ) + W'({nBdsQ, 4'b0000});
  assign wrNext     = (commitSum >= ringW) ? OFF_W'(commitSum - ringW) : OFF_W'(commitSum);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr0Q      <= '0;
      hdr1Q      <= '0;
      dataQ      <= '0;
      cursorQ    <= '0;
      wrOffsetQ  <= '0;
      nBdsQ      <= '0;
      nWordsQ    <= '0;
      stickyOvrQ <= 1'b0;
    end else begin
      if (strobe.drop) stickyOvrQ <= 1'b1;
      if (strobe.load) begin
        hdr0Q      <= hdr0In;
        hdr1Q      <= hdr1In;
        dataQ      <= frmData;
        cursorQ    <= wrOffsetQ;
        nBdsQ      <= inBds;
        nWordsQ    <= SEL_W'(inRound >> 3);
        stickyOvrQ <= 1'b0;
      end
      if (strobe.emit) cursorQ <= cursorNext;
      if (strobe.commit) wrOffsetQ <= wrNext;
    end
  end

  assign wordIdx  = (strobe.sel == '0) ? '0 : strobe.sel - 1'b1;
  assign memAddr  = cursorQ;
  assign memData  = (strobe.sel == '0) ? {hdr1Q, hdr0Q} : dataQ[32'(wordIdx)*64 +: 64];
  assign wrOffset = wrOffsetQ;

  assert_hdr_at_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (memAddr == $past(wrOffset)));

  assert_addr_in_ring_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (memAddr < ringSize));

  assert_offset_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(wrOffset));

  assert_never_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (wrOffset != $past(rdOffset)));

endmodule

// File: rtl/canfd_rx_ring_writer.sv
module canfd_rx_ring_writer
  import canfd_rx_ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [OFF_W-1:0]       ringSize,
  input  logic [OFF_W-1:0]       rdOffset,
  output logic [OFF_W-1:0]       wrOffset,
  input  logic                   frmValid,
  output logic                   frmReady,
  input  logic                   frmExt,
  input  logic                   frmRtr,
  input  logic [ID_W-1:0]        frmId,
  input  logic [3:0]             frmDlc,
  input  logic [OPT_W-1:0]       frmOpts,
  input  logic [MAX_BYTES*8-1:0] frmData,
  input  logic                   busOff,
  input  logic                   errPassive,
  output logic                   memWe,
  output logic [OFF_W-1:0]       memAddr,
  output logic [63:0]            memData
);

  ringStrobe_t      strobe;
  logic             fits;
  logic [SEL_W-1:0] nWordsQ;

  canfd_rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .enable(enable),
    .fits(fits), .nWordsQ(nWordsQ), .frmReady(frmReady), .strobe(strobe)
  );

  canfd_rx_ring_dp #(.OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ringSize(ringSize),
    .rdOffset(rdOffset), .frmExt(frmExt), .frmRtr(frmRtr), .frmId(frmId),
    .frmDlc(frmDlc), .frmOpts(frmOpts), .frmData(frmData), .busOff(busOff),
    .errPassive(errPassive), .fits(fits), .nWordsQ(nWordsQ),
    .wrOffset(wrOffset), .memAddr(memAddr), .memData(memData)
  );

  assign memWe = strobe.emit;

endmodule

// File: tb/canfd_rx_ring_writer_bench.sv
module canfd_rx_ring_writer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic [OFF_W-1:0] ringSize = 16'd128;
  logic [OFF_W-1:0] rdOffset = '0;
  logic [OFF_W-1:0] wrOffset;
  logic frmValid = 1'b0;
  logic frmReady;
  logic frmExt = 1'b0, frmRtr = 1'b0;
  logic [29:0] frmId = '0;
  logic [3:0] frmDlc = '0;
  logic [2:0] frmOpts = '0;
  logic [511:0] frmData = '0;
  logic busOff = 1'b0, errPassive = 1'b0;
  logic memWe;
  logic [OFF_W-1:0] memAddr;
  logic [63:0] memData;

  int checks = 0;
  int fails = 0;
  int wrCount = 0;
  logic readyAfter;
  logic [63:0] mem [0:15];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canfd_rx_ring_writer #(.OFF_W(OFF_W)) u_canfd_rx_ring_writer (
    .clk(clk), .rstN(rstN), .enable(enable), .ringSize(ringSize),
    .rdOffset(rdOffset), .wrOffset(wrOffset), .frmValid(frmValid),
    .frmReady(frmReady), .frmExt(frmExt), .frmRtr(frmRtr), .frmId(frmId),
    .frmDlc(frmDlc), .frmOpts(frmOpts), .frmData(frmData), .busOff(busOff),
    .errPassive(errPassive), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  always @(negedge clk) begin
    if (memWe) begin
      mem[memAddr[6:3]] = memData;
      wrCount++;
    end
  end

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hdrWord(input logic ext, input logic rtr, input logic [29:0] id,
      input logic [3:0] dlc, input logic [2:0] opts, input logic ovr, input logic bo, input logic ep);
    logic [31:0] h0, h1;
    h0 = ext ? {1'b1, rtr, id} : {1'b0, rtr, id[11:0], 18'd0};
    h1 = {dlc, opts, 22'd0, ovr, bo, ep};
    return {h1, h0};
  endfunction

  function automatic logic [63:0] payWord(input logic [7:0] seed, input int k);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = seed + 8'(8*k + b);
    return w;
  endfunction

  task automatic sendFrame(input logic ext, input logic rtr, input logic [29:0] id,
      input logic [3:0] dlc, input logic [2:0] opts, input logic [7:0] seed,
      input logic bo, input logic ep);
    @(negedge clk);
    wrCount = 0;
    frmExt = ext; frmRtr = rtr; frmId = id; frmDlc = dlc; frmOpts = opts;
    busOff = bo; errPassive = ep;
    for (int i = 0; i < 64; i++) frmData[8*i +: 8] = seed + 8'(i);
    frmValid = 1'b1;
    @(negedge clk);
    frmValid = 1'b0;
    busOff = 1'b0; errPassive = 1'b0;
    readyAfter = frmReady;
    repeat (12) @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    checkEq("R10 reset wrOffset", 64'(wrOffset), 64'd0);
    checkEq("R10 reset ready", 64'(frmReady), 64'd1);
    checkEq("R10 reset no write", 64'(memWe), 64'd0);
  endtask

  task automatic testClassicStd();
    sendFrame(1'b0, 1'b0, 30'h5A5, 4'd3, 3'b000, 8'h10, 1'b1, 1'b0);
    checkEq("R10 busy after accept", 64'(readyAfter), 64'd0);
    checkEq("R1 R2 R3 std header", mem[0], hdrWord(1'b0, 1'b0, 30'h5A5, 4'd3, 3'b000, 1'b0, 1'b1, 1'b0));
    checkEq("R4 classic dlc3 word", mem[1], payWord(8'h10, 0));
    checkEq("R4 write count", 64'(wrCount), 64'd2);
    checkEq("R6 offset after 1 desc", 64'(wrOffset), 64'd16);
  endtask

  task automatic testFdExt();
    sendFrame(1'b1, 1'b0, 30'h2ABCDEF1, 4'd13, 3'b011, 8'h20, 1'b0, 1'b1);
    checkEq("R1 R2 R3 ext header", mem[2], hdrWord(1'b1, 1'b0, 30'h2ABCDEF1, 4'd13, 3'b011, 1'b0, 1'b0, 1'b1));
    for (int k = 0; k < 4; k++) checkEq("R5 fd32 payload", mem[3+k], payWord(8'h20, k));
    checkEq("R4 fd32 count", 64'(wrCount), 64'd5);
    checkEq("R6 offset after 3 desc", 64'(wrOffset), 64'd64);
  endtask

  task automatic testClassicClamp();
    sendFrame(1'b0, 1'b1, 30'h123, 4'd12, 3'b000, 8'h40, 1'b0, 1'b0);
    checkEq("R2 raw dlc kept", mem[8], hdrWord(1'b0, 1'b1, 30'h123, 4'd12, 3'b000, 1'b0, 1'b0, 1'b0));
    checkEq("R4 clamp payload", mem[9], payWord(8'h40, 0));
    checkEq("R4 clamp count", 64'(wrCount), 64'd2);
    checkEq("R6 offset 80", 64'(wrOffset), 64'd80);
  endtask

  task automatic testWrap();
    rdOffset = 16'd80;
    sendFrame(1'b1, 1'b1, 30'h1234567, 4'd15, 3'b001, 8'h80, 1'b0, 1'b0);
    checkEq("R1 wrap header", mem[10], hdrWord(1'b1, 1'b1, 30'h1234567, 4'd15, 3'b001, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 5; k++) checkEq("R5 pre-wrap payload", mem[11+k], payWord(8'h80, k));
    for (int k = 5; k < 8; k++) checkEq("R5 post-wrap payload", mem[k-5], payWord(8'h80, k));
    checkEq("R4 fd64 count", 64'(wrCount), 64'd9);
    checkEq("R6 wrapped offset", 64'(wrOffset), 64'd32);
  endtask

  task automatic testOverrun();
    sendFrame(1'b0, 1'b0, 30'h7, 4'd13, 3'b001, 8'h55, 1'b0, 1'b0);
    checkEq("R7 no write on full", 64'(wrCount), 64'd0);
    checkEq("R7 offset kept", 64'(wrOffset), 64'd32);
    checkEq("R7 ready after drop", 64'(readyAfter), 64'd1);
    sendFrame(1'b0, 1'b0, 30'h9, 4'd10, 3'b001, 8'hC0, 1'b0, 1'b0);
    checkEq("R8 overrun flagged", mem[4], hdrWord(1'b0, 1'b0, 30'h9, 4'd10, 3'b001, 1'b1, 1'b0, 1'b0));
    checkEq("R7 fill to one free slot", 64'(wrOffset), 64'd64);
    checkEq("R5 fd16 word1", mem[6], payWord(8'hC0, 1));
    rdOffset = 16'd64;
    sendFrame(1'b0, 1'b0, 30'hA, 4'd0, 3'b000, 8'h01, 1'b0, 1'b0);
    checkEq("R8 overrun cleared", mem[8], hdrWord(1'b0, 1'b0, 30'hA, 4'd0, 3'b000, 1'b0, 1'b0, 1'b0));
    checkEq("R4 zero length count", 64'(wrCount), 64'd1);
    checkEq("R6 offset 80 again", 64'(wrOffset), 64'd80);
  endtask

  task automatic testDisabled();
    enable = 1'b0;
    sendFrame(1'b0, 1'b0, 30'hB, 4'd2, 3'b000, 8'h33, 1'b0, 1'b0);
    checkEq("R9 no write when disabled", 64'(wrCount), 64'd0);
    checkEq("R9 offset kept", 64'(wrOffset), 64'd80);
    enable = 1'b1;
    sendFrame(1'b0, 1'b0, 30'hC, 4'd1, 3'b000, 8'h66, 1'b0, 1'b0);
    checkEq("R9 overrun after disable", mem[10], hdrWord(1'b0, 1'b0, 30'hC, 4'd1, 3'b000, 1'b1, 1'b0, 1'b0));
    checkEq("R5 dlc1 payload", mem[11], payWord(8'h66, 0));
    checkEq("R6 offset 96", 64'(wrOffset), 64'd96);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testClassicStd();
    testFdExt();
    testClassicClamp();
    testWrap();
    testOverrun();
    testDisabled();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule